// File: doc/BRIEF.md
# Saturating Branch Sample Recorder

This block records taken branches into a small register file after a chosen performance counter overflows. Each retired taken branch arrives with its source and destination addresses. Once capture is enabled and the selected counter has overflowed, the block stores each branch in the entry at its next-write index and then advances that index. It makes one pass from the starting index up to the last entry and never goes back over older entries. When the last entry is filled, the index drops to zero and the block clears its own enable bit.

The counter's overflow interrupt is not passed on when it happens. It is held while the buffer fills and is delivered as a one-cycle pulse when the buffer becomes full. If software rewrites the configuration while the interrupt is held, the interrupt is delivered at once. Software reaches the configuration register and every entry register through one flat register port. The entry registers are plain read/write storage, so software can leave a marker value in any of them.

Top module: `bsr_recorder`

## Requirements
- R1: After reset the configuration register reads 0x18: enable clear, valid flag clear, next-write index 0, counter select 0. The interrupt output is low.
- R2: The configuration register (address 2*DEPTH) always reads bits 4:3 as 11b, whatever value was written to them.
- R3: A branch is recorded only when the enable (bit 2) is set and the overflow input picked by the counter-select field (bits 27:24) was seen in an earlier cycle. Branches before that point, branches in the same cycle as the overflow, and overflows on other counters record nothing.
- R4: A recorded branch puts its source address in the register at address 2*i and its destination in the register at 2*i+1, where i is the next-write index (bits 19:16). The index then increases by one and the valid flag (bit 5) is set.
- R5: Recording the last entry (index DEPTH-1) sets the index to 0 and clears the enable. After that no branch is recorded, and entries written earlier keep their values.
- R6: The interrupt is a one-cycle pulse in the cycle after the full buffer is reached, and it never fires while capture is still in progress.
- R7: A configuration write while an overflow is held delivers the interrupt pulse in the next cycle. A write with the enable bit 0 keeps the index and valid flag as they were. Clearing the enable when no overflow is held raises no interrupt.
- R8: A configuration write with the enable bit 1 loads the index, the valid flag and the counter select from the written value, and it discards any held state.
- R9: Software can write and read back the entry registers. If a software write hits the same entry that hardware is recording in that cycle, the hardware value wins.
- R10: A configuration write in the same cycle as a branch or overflow takes priority, so that branch is not recorded and that overflow is not held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_valid | input | 1 | A taken branch retired this cycle |
| br_from | input | ADDR_W | Branch source address |
| br_to | input | ADDR_W | Branch destination address |
| ovf_in | input | NCTR | Overflow pulses, one per performance counter |
| reg_we | input | 1 | Register port write strobe |
| reg_addr | input | RA_W | Register address: entries at 0..2*DEPTH-1, configuration at 2*DEPTH |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational from reg_addr) |
| irq | output | 1 | Delivered overflow interrupt pulse |

## Verification
Software traffic on the register port can land in the same cycle as hardware capture in two ways. A software write to the entry that is being recorded is provoked on purpose, and the bench expects the captured address pair to be stored. A configuration rewrite issued together with a retiring branch, while an overflow is held, is also provoked. For that case the bench expects three things: the target entry keeps its old contents, the index is taken from the written value, and the held interrupt pulses in the next cycle. A behavioural model compares the read data and the interrupt on every cycle, so a wrong priority shows up in the cycle where it happens.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
    localparam int CFG_EN_BIT  = 2;
    localparam int CFG_RSV_LO  = 3;
    localparam int CFG_VB_BIT  = 5;
    localparam int CFG_IDX_LO  = 16;
    localparam int CFG_IDX_W   = 4;
    localparam int CFG_SEL_LO  = 24;
    localparam int CFG_SEL_W   = 4;

    function automatic logic [63:0] pack_cfg(input logic en, input logic vb,
                                             input logic [CFG_IDX_W-1:0] idx,
                                             input logic [CFG_SEL_W-1:0] sel);
        logic [63:0] v;
        v = '0;
        v[CFG_EN_BIT] = en;
        v[CFG_RSV_LO +: 2] = 2'b11;
        v[CFG_VB_BIT] = vb;
        v[CFG_IDX_LO +: CFG_IDX_W] = idx;
        v[CFG_SEL_LO +: CFG_SEL_W] = sel;
        return v;
    endfunction
endpackage

// File: rtl/bsr_ovf_pick.sv
module bsr_ovf_pick #(
    parameter int NCTR  = 8,
    parameter int SEL_W = 4
) (
    input  logic [NCTR-1:0]  ovf_in,
    input  logic [SEL_W-1:0] sel,
    output logic             ovf_sel
);
    logic [NCTR-1:0] hit;

    for (genvar g = 0; g < NCTR; g++) begin : g_pick
        assign hit[g] = ovf_in[g] && (sel == SEL_W'(g));
    end

    assign ovf_sel = |hit;
endmodule

// File: rtl/bsr_ctl.sv
module bsr_ctl #(
    parameter int DEPTH = 16,
    parameter int SEL_W = 4,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_en_w,
    input  logic             cfg_vb_w,
    input  logic [IDX_W-1:0] cfg_idx_w,
    input  logic [SEL_W-1:0] cfg_sel_w,
    input  logic             br_valid,
    input  logic             ovf_sel,
    output logic             en_o,
    output logic             vb_o,
    output logic [IDX_W-1:0] idx_o,
    output logic [SEL_W-1:0] sel_o,
    output logic             cap_o,
    output logic             irq_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    typedef struct packed {
        logic             en;
        logic             vb;
        logic             held;
        logic             irq;
        logic [IDX_W-1:0] idx;
        logic [SEL_W-1:0] sel;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic cap_d;

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.irq = 1'b0;
        cap_d     = 1'b0;
        if (cfg_we) begin
            if (ctl_q.held) begin
                ctl_d.irq  = 1'b1;
                ctl_d.held = 1'b0;
            end
            ctl_d.sel = cfg_sel_w;
            ctl_d.en  = cfg_en_w;
            if (cfg_en_w) begin
                ctl_d.vb  = cfg_vb_w;
                ctl_d.idx = cfg_idx_w;
            end
        end else begin
            if (ctl_q.en && ctl_q.held && br_valid) begin
                cap_d    = 1'b1;
                ctl_d.vb = 1'b1;
                if (ctl_q.idx == LAST_IDX) begin
                    ctl_d.idx  = '0;
                    ctl_d.en   = 1'b0;
                    ctl_d.held = 1'b0;
                    ctl_d.irq  = 1'b1;
                end else begin
                    ctl_d.idx = ctl_q.idx + 1'b1;
                end
            end
            if (ctl_q.en && !ctl_q.held && ovf_sel) begin
                ctl_d.held = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign en_o  = ctl_q.en;
    assign vb_o  = ctl_q.vb;
    assign idx_o = ctl_q.idx;
    assign sel_o = ctl_q.sel;
    assign cap_o = cap_d;
    assign irq_o = ctl_q.irq;

    p_wrap_stops_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_o && idx_o == LAST_IDX) |=> (!en_o && idx_o == '0 && irq_o));

    p_irq_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    p_irq_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(cfg_we || cap_o));

    p_clear_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_en_w) |=> ($stable(idx_o) && $stable(vb_o) && !en_o));

    p_valid_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cap_o |=> vb_o);

    p_no_cap_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_o) |-> !cap_o);
endmodule

// File: rtl/bsr_entry_file.sv
module bsr_entry_file #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 48,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_we,
    input  logic [IDX_W-1:0]  sw_idx,
    input  logic              sw_hi,
    input  logic [ADDR_W-1:0] sw_data,
    input  logic              hw_we,
    input  logic [IDX_W-1:0]  hw_idx,
    input  logic [ADDR_W-1:0] hw_from,
    input  logic [ADDR_W-1:0] hw_to,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic              rd_hi,
    output logic [ADDR_W-1:0] rd_data
);
    typedef struct packed {
        logic [ADDR_W-1:0] from_a;
        logic [ADDR_W-1:0] to_a;
    } ent_t;

    logic [ADDR_W-1:0] from_v [DEPTH];
    logic [ADDR_W-1:0] to_v   [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        ent_t ent_d, ent_q;

        always_comb begin
            ent_d = ent_q;
            if (sw_we && sw_idx == IDX_W'(g)) begin
                if (sw_hi) begin
                    ent_d.to_a = sw_data;
                end else begin
                    ent_d.from_a = sw_data;
                end
            end
            if (hw_we && hw_idx == IDX_W'(g)) begin
                ent_d.from_a = hw_from;
                ent_d.to_a   = hw_to;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q <= '0;
            end else begin
                ent_q <= ent_d;
            end
        end

        assign from_v[g] = ent_q.from_a;
        assign to_v[g]   = ent_q.to_a;
    end

    assign rd_data = rd_hi ? to_v[rd_idx] : from_v[rd_idx];

    logic              chk_v_q;
    logic [IDX_W-1:0]  chk_idx_q;
    logic [ADDR_W-1:0] chk_from_q, chk_to_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_v_q    <= 1'b0;
            chk_idx_q  <= '0;
            chk_from_q <= '0;
            chk_to_q   <= '0;
        end else begin
            chk_v_q    <= hw_we;
            chk_idx_q  <= hw_idx;
            chk_from_q <= hw_from;
            chk_to_q   <= hw_to;
        end
    end

    p_hw_stored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        chk_v_q |-> (from_v[chk_idx_q] == chk_from_q && to_v[chk_idx_q] == chk_to_q));

    p_sw_stored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_we && !(hw_we && hw_idx == sw_idx)) |=>
        ((sw_hi ? to_v[$past(sw_idx)] : from_v[$past(sw_idx)]) == $past(sw_data)));
endmodule

// File: rtl/bsr_recorder.sv
module bsr_recorder #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 48,
    parameter int NCTR   = 8,
    localparam int DATA_W = 64,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int RA_W   = IDX_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              br_valid,
    input  logic [ADDR_W-1:0] br_from,
    input  logic [ADDR_W-1:0] br_to,
    input  logic [NCTR-1:0]   ovf_in,
    input  logic              reg_we,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    import bsr_pkg::*;

    localparam logic [RA_W-1:0] CFG_ADDR = RA_W'(2 * DEPTH);
    localparam int SEL_W = CFG_SEL_W;

    logic             is_cfg, is_ent;
    logic             en, vb, cap, ovf_sel;
    logic [IDX_W-1:0] idx;
    logic [SEL_W-1:0] sel;
    logic [ADDR_W-1:0] ent_rd;
    logic [DATA_W-ADDR_W-1:0] wdata_unused;

    assign wdata_unused = reg_wdata[DATA_W-1:ADDR_W];
    assign is_cfg = (reg_addr == CFG_ADDR);
    assign is_ent = (reg_addr < CFG_ADDR);

    bsr_ovf_pick #(.NCTR(NCTR), .SEL_W(SEL_W)) u_pick (
        .ovf_in (ovf_in),
        .sel    (sel),
        .ovf_sel(ovf_sel)
    );

    bsr_ctl #(.DEPTH(DEPTH), .SEL_W(SEL_W)) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (reg_we && is_cfg),
        .cfg_en_w (reg_wdata[CFG_EN_BIT]),
        .cfg_vb_w (reg_wdata[CFG_VB_BIT]),
        .cfg_idx_w(reg_wdata[CFG_IDX_LO +: IDX_W]),
        .cfg_sel_w(reg_wdata[CFG_SEL_LO +: SEL_W]),
        .br_valid (br_valid),
        .ovf_sel  (ovf_sel),
        .en_o     (en),
        .vb_o     (vb),
        .idx_o    (idx),
        .sel_o    (sel),
        .cap_o    (cap),
        .irq_o    (irq)
    );

    bsr_entry_file #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ent (
        .clk    (clk),
        .rst_n  (rst_n),
        .sw_we  (reg_we && is_ent),
        .sw_idx (reg_addr[IDX_W:1]),
        .sw_hi  (reg_addr[0]),
        .sw_data(reg_wdata[ADDR_W-1:0]),
        .hw_we  (cap),
        .hw_idx (idx),
        .hw_from(br_from),
        .hw_to  (br_to),
        .rd_idx (reg_addr[IDX_W:1]),
        .rd_hi  (reg_addr[0]),
        .rd_data(ent_rd)
    );

    always_comb begin
        reg_rdata = '0;
        if (is_cfg) begin
            reg_rdata = pack_cfg(en, vb, CFG_IDX_W'(idx), sel);
        end else if (is_ent) begin
            reg_rdata = {{(DATA_W-ADDR_W){1'b0}}, ent_rd};
        end
    end

    p_rsv_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        is_cfg |-> (reg_rdata[CFG_RSV_LO +: 2] == 2'b11));
endmodule

// File: tb/test_bsr_recorder.sv
`timescale 1ns/1ps
module test_bsr_recorder;
    localparam int DEPTH = 16;
    localparam int AW = 48;
    localparam int NC = 8;
    localparam logic [5:0] CFGA = 6'd32;

    logic clk = 0, rst_n = 0;
    logic br_valid = 0;
    logic [AW-1:0] br_from = '0, br_to = '0;
    logic [NC-1:0] ovf_in = '0;
    logic reg_we = 0;
    logic [5:0] reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic irq;

    int checks = 0, failures = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    bsr_recorder i_bsr_recorder (
        .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_from(br_from), .br_to(br_to),
        .ovf_in(ovf_in), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    // behavioural reference
    int m_en, m_vb, m_idx, m_sel, m_held, m_irq;
    logic [AW-1:0] m_from [DEPTH];
    logic [AW-1:0] m_to   [DEPTH];

    function automatic logic [63:0] cfgv(int en, int vb, int idx, int sel);
        return (64'(sel) << 24) | (64'(idx) << 16) | (64'(vb) << 5) | 64'h18 | (64'(en) << 2);
    endfunction

    task automatic m_reset();
        m_en = 0; m_vb = 0; m_idx = 0; m_sel = 0; m_held = 0; m_irq = 0;
        for (int i = 0; i < DEPTH; i++) begin m_from[i] = '0; m_to[i] = '0; end
    endtask

    initial m_reset();

    always @(posedge clk) begin
        if (!rst_n) begin
            m_reset();
        end else begin
            int ci;
            bit cap;
            m_irq = 0;
            cap = 0;
            ci = m_idx;
            if (reg_we && reg_addr < CFGA) begin
                if (reg_addr[0]) m_to[reg_addr[4:1]] = reg_wdata[AW-1:0];
                else m_from[reg_addr[4:1]] = reg_wdata[AW-1:0];
            end
            if (reg_we && reg_addr == CFGA) begin
                if (m_held != 0) begin m_irq = 1; m_held = 0; end
                m_sel = int'(reg_wdata[27:24]);
                m_en = int'(reg_wdata[2]);
                if (reg_wdata[2]) begin
                    m_vb = int'(reg_wdata[5]);
                    m_idx = int'(reg_wdata[19:16]);
                end
            end else begin
                cap = (m_en != 0) && (m_held != 0) && br_valid;
                if (m_en != 0 && m_held == 0 && m_sel < NC && ovf_in[m_sel]) m_held = 1;
                if (cap) begin
                    m_from[ci] = br_from;
                    m_to[ci] = br_to;
                    m_vb = 1;
                    if (ci == DEPTH - 1) begin
                        m_idx = 0; m_en = 0; m_held = 0; m_irq = 1;
                    end else begin
                        m_idx = ci + 1;
                    end
                end
            end
        end
    end

    function automatic logic [63:0] m_read(logic [5:0] a);
        if (a == CFGA) return cfgv(m_en, m_vb, m_idx, m_sel);
        if (a < CFGA) return a[0] ? 64'(m_to[a[4:1]]) : 64'(m_from[a[4:1]]);
        return 64'h0;
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n) begin
            chk(cur_req, 64'(irq), 64'(m_irq));
            chk(cur_req, reg_rdata, m_read(reg_addr));
        end
    end

    task automatic step(logic b, logic [AW-1:0] f, logic [AW-1:0] t, logic [NC-1:0] o,
                        logic we, logic [5:0] a, logic [63:0] wd);
        br_valid = b; br_from = f; br_to = t; ovf_in = o;
        reg_we = we; reg_addr = a; reg_wdata = wd;
        @(posedge clk); #1;
        br_valid = 0; ovf_in = '0; reg_we = 0;
    endtask

    task automatic wcfg(logic [63:0] wd);
        step(0, '0, '0, '0, 1, CFGA, wd);
    endtask

    task automatic br(logic [AW-1:0] f, logic [AW-1:0] t);
        step(1, f, t, '0, 0, CFGA, '0);
    endtask

    task automatic rd(logic [5:0] a, logic [63:0] exp, string tag);
        reg_addr = a;
        @(negedge clk);
        chk(tag, reg_rdata, exp);
        @(posedge clk); #1;
    endtask

    initial begin
        #(5.0 * 200000);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        reg_addr = CFGA;
        // R1
        cur_req = "R1";
        rd(CFGA, 64'h18, "R1");
        chk("R1", 64'(irq), 64'h0);

        // R2
        cur_req = "R2";
        wcfg(64'h0);
        rd(CFGA, 64'h18, "R2");
        wcfg(64'h0500_0000);
        rd(CFGA, cfgv(0, 0, 0, 5), "R2");

        // R3
        cur_req = "R3";
        wcfg(cfgv(1, 0, 0, 3));
        br(48'h111, 48'h222);
        rd(CFGA, cfgv(1, 0, 0, 3), "R3");
        step(1, 48'h333, 48'h444, 8'h20, 0, CFGA, '0);
        br(48'h555, 48'h666);
        rd(CFGA, cfgv(1, 0, 0, 3), "R3");
        step(1, 48'h777, 48'h888, 8'h08, 0, CFGA, '0);
        rd(CFGA, cfgv(1, 0, 0, 3), "R3");

        // R4
        cur_req = "R4";
        for (int i = 0; i < 3; i++) br(48'h1000 + 48'(i), 48'h2000 + 48'(i));
        rd(CFGA, cfgv(1, 1, 3, 3), "R4");
        rd(6'd0, 64'h1000, "R4");
        rd(6'd1, 64'h2000, "R4");
        rd(6'd5, 64'h2002, "R4");
        chk("R6", 64'(irq), 64'h0);

        // R5 / R6
        cur_req = "R5";
        for (int i = 3; i < 15; i++) br(48'h1000 + 48'(i), 48'h2000 + 48'(i));
        chk("R6", 64'(irq), 64'h0);
        br(48'h100F, 48'h200F);
        chk("R6", 64'(irq), 64'h1);
        step(0, '0, '0, '0, 0, CFGA, '0);
        chk("R6", 64'(irq), 64'h0);
        rd(CFGA, cfgv(0, 1, 0, 3), "R5");
        br(48'hDEAD, 48'hBEEF);
        rd(6'd0, 64'h1000, "R5");
        rd(6'd30, 64'h100F, "R5");

        // R7
        cur_req = "R7";
        wcfg(cfgv(1, 0, 4, 3));
        step(0, '0, '0, 8'h08, 0, CFGA, '0);
        br(48'h3000, 48'h3100);
        br(48'h3001, 48'h3101);
        wcfg(cfgv(0, 0, 0, 3));
        chk("R7", 64'(irq), 64'h1);
        rd(CFGA, cfgv(0, 1, 6, 3), "R7");
        rd(6'd10, 64'h3001, "R7");
        wcfg(cfgv(1, 0, 0, 3));
        wcfg(cfgv(0, 0, 0, 3));
        chk("R7", 64'(irq), 64'h0);

        // R8
        cur_req = "R8";
        wcfg(cfgv(1, 1, 10, 2));
        rd(CFGA, cfgv(1, 1, 10, 2), "R8");

        // R9
        cur_req = "R9";
        step(0, '0, '0, '0, 1, 6'd9, 64'hFFFF_FFFF_FFFE);
        rd(6'd9, 64'hFFFF_FFFF_FFFE, "R9");
        wcfg(cfgv(1, 0, 7, 0));
        step(0, '0, '0, 8'h01, 0, CFGA, '0);
        step(1, 48'h4000, 48'h5000, '0, 1, 6'd15, 64'hAAAA);
        rd(6'd15, 64'h5000, "R9");
        rd(6'd14, 64'h4000, "R9");

        // R10
        cur_req = "R10";
        step(1, 48'h6000, 48'h6100, 8'h01, 1, CFGA, cfgv(1, 0, 8, 0));
        chk("R10", 64'(irq), 64'h1);
        rd(6'd16, 64'h1008, "R10");
        rd(CFGA, cfgv(1, 0, 8, 0), "R10");
        br(48'h6001, 48'h6101);
        rd(CFGA, cfgv(1, 0, 8, 0), "R10");

        // wrap from a nonzero start (R5)
        cur_req = "R5";
        step(0, '0, '0, 8'h01, 0, CFGA, '0);
        for (int i = 8; i < 15; i++) br(48'h7000 + 48'(i), 48'h7100 + 48'(i));
        chk("R6", 64'(irq), 64'h0);
        br(48'h700F, 48'h710F);
        chk("R5", 64'(irq), 64'h1);
        rd(CFGA, cfgv(0, 1, 0, 0), "R5");
        rd(6'd16, 64'h7008, "R5");
        rd(6'd0, 64'h1000, "R5");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule